// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address into a physical address after a translation lookaside buffer has missed. A request carries the 32-bit virtual address and the base of the first-level translation table. The walker reads one descriptor at a time through a single-beat memory read port. For some mappings it then follows a pointer to a second-level table and reads a second descriptor. It returns the result in the form a TLB entry needs: the physical address, a page-size code and three per-page attribute fields. If the walk finds an invalid descriptor, it reports a fault instead.

Four mapping granules are supported. A first-level descriptor can map a whole 1 MB section or a 16 MB supersection. A second-level descriptor can map a 64 KB large page or a 4 KB small page. Supersection and large-page descriptors are stored as sixteen identical replicas. The walker therefore decodes whichever replica the virtual address selects and takes the page base only from the upper address bits. The attribute fields sit in different bit positions at the two levels, and the walker moves them into one common result format.

Top module: `ptw_walker`

## Requirements
- R1: After reset, busy_o, mem_rd_o and done_o are all 0.
- R2: A start_i pulse while busy_o is 0 makes mem_rd_o high in the next cycle. The address is {ttb_i[31:14], vaddr_i[31:20], 2'b00}. The low 14 bits of ttb_i have no effect.
- R3: Each read is a single-cycle mem_rd_o pulse. No further read is issued until mem_rvalid_i has returned the data for the previous one.
- R4: A first-level descriptor with bits [1:0]=2 and bit 18=0 is a 1 MB section. The result is pa={d[31:20], va[19:0]} and size code 0. The attributes are endian=d[15], element size=d[11:10] and mixed=d[17].
- R5: A first-level descriptor with bits [1:0]=2 and bit 18=1 is a 16 MB supersection. The result is pa={d[31:24], va[23:0]} and size code 3, with the same attribute positions as R4. Every replica yields the same base, whatever d[23:19] holds.
- R6: A first-level descriptor with bits [1:0]=1 leads to exactly one second-level read. That read is at {d[31:10], va[19:12], 2'b00}.
- R7: A second-level descriptor with bits [1:0]=2 is a 4 KB small page. The result is pa={d[31:12], va[11:0]} and size code 2. The attributes are endian=d[9], element size=d[5:4] and mixed=d[11].
- R8: A second-level descriptor with bits [1:0]=1 is a 64 KB large page. The result is pa={d[31:16], va[15:0]} and size code 1, with the attribute positions of R7.
- R9: A descriptor with bits [1:0] equal to 0 or 3, at either level, ends the walk. done_o and fault_o rise together, and no further read is issued. fault_lvl2_o tells which level faulted: 0 for the first level, 1 for the second.
- R10: start_i is ignored while busy_o is 1, and this includes the cycle in which done_o is high. mem_rvalid_i is ignored outside the wait states.
- R11: done_o is high for exactly one cycle, in the cycle after the mem_rvalid_i that completed the walk. busy_o is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| vaddr_i | input | 32 | Virtual address to translate |
| ttb_i | input | 32 | First-level table base (16 KB aligned) |
| busy_o | output | 1 | Walk in progress |
| mem_rd_o | output | 1 | Single-cycle read request |
| mem_addr_o | output | 32 | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (descriptor) |
| done_o | output | 1 | Walk finished (result or fault) |
| fault_o | output | 1 | Walk ended in a translation fault |
| fault_lvl2_o | output | 1 | Fault was at the second level |
| res_pa_o | output | 32 | Translated physical address |
| res_size_o | output | 2 | Size code: 0 section, 1 large, 2 small, 3 supersection |
| res_endian_o | output | 1 | Endianness attribute |
| res_elsize_o | output | 2 | Element-size attribute |
| res_mixed_o | output | 1 | Mixed-size attribute |

## Verification
Two events can land on the same clock edge: a new start request and the completion of the current walk. The bench therefore holds start_i high, with a different address, through both wait phases and through the cycle in which done_o is high. It then checks that exactly the expected reads were issued, at the expected addresses, and that busy_o and mem_rd_o are low in the cycle after done_o. A stray mem_rvalid_i while the walker is idle is also driven, and the bench checks that no completion is produced.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned AW          = 32;
    localparam int unsigned TBL_ALIGN   = 14;   // first-level table alignment
    localparam int unsigned LNK_ALIGN   = 10;   // second-level table alignment
    localparam int unsigned L1_IDX_LSB  = 20;
    localparam int unsigned L2_IDX_LSB  = 12;
    localparam int unsigned L2_IDX_W    = L1_IDX_LSB - L2_IDX_LSB;
    localparam int unsigned SECT_LSB    = 20;
    localparam int unsigned SUPER_LSB   = 24;
    localparam int unsigned LARGE_LSB   = 16;
    localparam int unsigned SMALL_LSB   = 12;

    typedef enum logic [1:0] {
        PG_SECTION = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SMALL   = 2'd2,
        PG_SUPER   = 2'd3
    } pg_size_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_ISSUE, ST_L1_WAIT, ST_L2_ISSUE, ST_L2_WAIT, ST_RESP
    } walk_st_e;

    typedef struct packed {
        logic [AW-1:0] pa;
        pg_size_e      size;
        logic          big_endian;
        logic [1:0]    elem_size;
        logic          mixed;
    } xlat_t;

    // Upper bits from the descriptor, bits below lsb from the virtual address.
    function automatic logic [AW-1:0] splice(input logic [AW-1:0] hi,
                                             input logic [AW-1:0] lo,
                                             input int unsigned   lsb);
        logic [AW-1:0] keep;
        keep = {AW{1'b1}} << lsb;
        return (hi & keep) | (lo & ~keep);
    endfunction

endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
    import ptw_pkg::*;
(
    input  logic [AW-1:0] desc_i,
    input  logic [AW-1:0] va_i,
    output logic          block_o,
    output logic          link_o,
    output logic [AW-1:0] l2_addr_o,
    output xlat_t         res_o
);
    logic super_sel;

    always_comb begin
        block_o   = (desc_i[1:0] == 2'd2);
        link_o    = (desc_i[1:0] == 2'd1);
        super_sel = desc_i[18];
        l2_addr_o = {desc_i[AW-1:LNK_ALIGN], va_i[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};

        res_o            = '0;
        res_o.big_endian = desc_i[15];
        res_o.elem_size  = desc_i[11:10];
        res_o.mixed      = desc_i[17];
        if (super_sel) begin
            res_o.pa   = splice(desc_i, va_i, SUPER_LSB);
            res_o.size = PG_SUPER;
        end else begin
            res_o.pa   = splice(desc_i, va_i, SECT_LSB);
            res_o.size = PG_SECTION;
        end
    end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
(
    input  logic [AW-1:0] desc_i,
    input  logic [AW-1:0] va_i,
    output logic          page_o,
    output xlat_t         res_o
);
    always_comb begin
        page_o           = (desc_i[1:0] == 2'd1) || (desc_i[1:0] == 2'd2);
        res_o            = '0;
        res_o.big_endian = desc_i[9];
        res_o.elem_size  = desc_i[5:4];
        res_o.mixed      = desc_i[11];
        if (desc_i[1:0] == 2'd1) begin
            res_o.pa   = splice(desc_i, va_i, LARGE_LSB);
            res_o.size = PG_LARGE;
        end else begin
            res_o.pa   = splice(desc_i, va_i, SMALL_LSB);
            res_o.size = PG_SMALL;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [31:0]   vaddr_i,
    input  logic [31:0]   ttb_i,
    output logic          busy_o,
    output logic          mem_rd_o,
    output logic [31:0]   mem_addr_o,
    input  logic          mem_rvalid_i,
    input  logic [31:0]   mem_rdata_i,
    output logic          done_o,
    output logic          fault_o,
    output logic          fault_lvl2_o,
    output logic [31:0]   res_pa_o,
    output logic [1:0]    res_size_o,
    output logic          res_endian_o,
    output logic [1:0]    res_elsize_o,
    output logic          res_mixed_o
);
    walk_st_e      st;
    logic [AW-1:0] va_q;
    logic [AW-1:0] l1_addr_q;
    logic [AW-1:0] l2_addr_q;
    xlat_t         res_q;
    logic          fault_q;
    logic          flt_l2_q;

    logic          l1_block, l1_link, l2_page;
    logic [AW-1:0] l1_next;
    xlat_t         l1_res, l2_res;

    ptw_l1_decode u_l1 (
        .desc_i    (mem_rdata_i),
        .va_i      (va_q),
        .block_o   (l1_block),
        .link_o    (l1_link),
        .l2_addr_o (l1_next),
        .res_o     (l1_res)
    );

    ptw_l2_decode u_l2 (
        .desc_i (mem_rdata_i),
        .va_i   (va_q),
        .page_o (l2_page),
        .res_o  (l2_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            va_q      <= '0;
            l1_addr_q <= '0;
            l2_addr_q <= '0;
            res_q     <= '0;
            fault_q   <= 1'b0;
            flt_l2_q  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start_i) begin
                    va_q      <= vaddr_i;
                    l1_addr_q <= {ttb_i[AW-1:TBL_ALIGN], vaddr_i[AW-1:L1_IDX_LSB], 2'b00};
                    st        <= ST_L1_ISSUE;
                end
                ST_L1_ISSUE: st <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rvalid_i) begin
                    if (l1_block) begin
                        res_q    <= l1_res;
                        fault_q  <= 1'b0;
                        flt_l2_q <= 1'b0;
                        st       <= ST_RESP;
                    end else if (l1_link) begin
                        l2_addr_q <= l1_next;
                        st        <= ST_L2_ISSUE;
                    end else begin
                        res_q    <= '0;
                        fault_q  <= 1'b1;
                        flt_l2_q <= 1'b0;
                        st       <= ST_RESP;
                    end
                end
                ST_L2_ISSUE: st <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rvalid_i) begin
                    res_q    <= l2_page ? l2_res : '0;
                    fault_q  <= !l2_page;
                    flt_l2_q <= !l2_page;
                    st       <= ST_RESP;
                end
                ST_RESP: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o       = (st != ST_IDLE);
        mem_rd_o     = (st == ST_L1_ISSUE) || (st == ST_L2_ISSUE);
        mem_addr_o   = (st == ST_L2_ISSUE) ? l2_addr_q : l1_addr_q;
        done_o       = (st == ST_RESP);
        fault_o      = done_o && fault_q;
        fault_lvl2_o = done_o && flt_l2_q;
        res_pa_o     = res_q.pa;
        res_size_o   = res_q.size;
        res_endian_o = res_q.big_endian;
        res_elsize_o = res_q.elem_size;
        res_mixed_o  = res_q.mixed;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        busy_o,
    input logic        mem_rd_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_rvalid_i,
    input logic        done_o,
    input logic        fault_o
);
    a_r3_read_single_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> !mem_rd_o);

    a_r2_start_issues_read: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (mem_rd_o && mem_addr_o[1:0] == 2'b00));

    a_r11_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    a_r11_done_after_rvalid: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(mem_rvalid_i));

    a_r9_fault_ends_walk: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> !mem_rd_o);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .done_o       (done_o),
    .fault_o      (fault_o)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] vaddr_i, ttb_i;
    logic        busy_o, mem_rd_o, mem_rvalid_i;
    logic [31:0] mem_addr_o, mem_rdata_i;
    logic        done_o, fault_o, fault_lvl2_o;
    logic [31:0] res_pa_o;
    logic [1:0]  res_size_o, res_elsize_o;
    logic        res_endian_o, res_mixed_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .vaddr_i(vaddr_i), .ttb_i(ttb_i),
        .busy_o(busy_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .fault_o(fault_o), .fault_lvl2_o(fault_lvl2_o),
        .res_pa_o(res_pa_o), .res_size_o(res_size_o), .res_endian_o(res_endian_o),
        .res_elsize_o(res_elsize_o), .res_mixed_o(res_mixed_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Captured per walk
    int          rd_cnt;
    logic [31:0] rd_addr [2];
    logic        got_done;

    // One walk: answer each read with lat cycles of delay; hammer keeps start high.
    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input logic [31:0] d1, input logic [31:0] d2,
                        input int lat, input bit hammer);
        int cnt = -1;
        rd_cnt   = 0;
        got_done = 1'b0;
        @(negedge clk);
        start_i = 1'b1; vaddr_i = va; ttb_i = base;
        for (int cyc = 0; cyc < 60; cyc++) begin
            @(negedge clk);
            mem_rvalid_i = 1'b0;
            if (hammer) begin
                start_i = 1'b1; vaddr_i = 32'hFFFF_F000; ttb_i = 32'h0000_0000;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) begin
                got_done = 1'b1;
                break;
            end
            if (mem_rd_o) begin
                if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr_o;
                rd_cnt++;
                cnt = lat;
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = (rd_cnt == 1) ? d1 : d2;
                    cnt = -1;
                end
            end
        end
    endtask

    task automatic after_done(input string req);
        @(negedge clk);
        chk({req, " busy after done"}, {31'd0, busy_o}, 32'd0);
        chk({req, " done one cycle"}, {31'd0, done_o}, 32'd0);
        chk({req, " no read after done"}, {31'd0, mem_rd_o}, 32'd0);
        start_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_xlat(input string req, input logic [31:0] pa, input logic [1:0] sz,
                              input logic e, input logic [1:0] es, input logic m);
        chk({req, " done"}, {31'd0, got_done}, 32'd1);
        chk({req, " fault"}, {31'd0, fault_o}, 32'd0);
        chk({req, " pa"}, res_pa_o, pa);
        chk({req, " size"}, {30'd0, res_size_o}, {30'd0, sz});
        chk({req, " endian"}, {31'd0, res_endian_o}, {31'd0, e});
        chk({req, " elsize"}, {30'd0, res_elsize_o}, {30'd0, es});
        chk({req, " mixed"}, {31'd0, res_mixed_o}, {31'd0, m});
    endtask

    task automatic t_reset();
        rst = 1'b1; start_i = 1'b0; vaddr_i = '0; ttb_i = '0;
        mem_rvalid_i = 1'b0; mem_rdata_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", {31'd0, busy_o}, 32'd0);
        chk("R1 rd", {31'd0, mem_rd_o}, 32'd0);
        chk("R1 done", {31'd0, done_o}, 32'd0);
    endtask

    task automatic t_section();
        walk(32'h1234_5678, 32'h8000_4ABC, 32'hABC0_8802, 32'h0, 1, 1'b0);
        chk("R2 l1 addr", rd_addr[0], 32'h8000_448C);
        chk("R4 one read", rd_cnt, 1);
        check_xlat("R4 section", 32'hABC4_5678, 2'd0, 1'b1, 2'd2, 1'b0);
        after_done("R11");
    endtask

    task automatic t_super();
        walk(32'h1234_5678, 32'h8000_4000, 32'h5516_0402, 32'h0, 2, 1'b0);
        chk("R5 one read", rd_cnt, 1);
        check_xlat("R5 super", 32'h5534_5678, 2'd3, 1'b0, 2'd1, 1'b1);
        after_done("R5");
        walk(32'h12F0_0001, 32'h8000_4000, 32'h5516_0402, 32'h0, 1, 1'b0);
        chk("R5 replica addr", rd_addr[0], 32'h8000_44BC);
        check_xlat("R5 replica", 32'h55F0_0001, 2'd3, 1'b0, 2'd1, 1'b1);
        after_done("R5");
    endtask

    task automatic t_small();
        walk(32'h0040_3ABC, 32'h8000_4000, 32'h1234_5801, 32'h9876_5A32, 1, 1'b0);
        chk("R6 two reads", rd_cnt, 2);
        chk("R2 l1 addr", rd_addr[0], 32'h8000_4010);
        chk("R6 l2 addr", rd_addr[1], 32'h1234_580C);
        check_xlat("R7 small", 32'h9876_5ABC, 2'd2, 1'b1, 2'd3, 1'b1);
        after_done("R7");
    endtask

    task automatic t_large_hammer();
        walk(32'h0047_9DEF, 32'h8000_4000, 32'h2000_0C01, 32'h7777_1011, 3, 1'b1);
        chk("R10 reads under start", rd_cnt, 2);
        chk("R10 l1 addr", rd_addr[0], 32'h8000_4010);
        chk("R6 l2 addr", rd_addr[1], 32'h2000_0DE4);
        check_xlat("R8 large", 32'h7777_9DEF, 2'd1, 1'b0, 2'd1, 1'b0);
        after_done("R10");
    endtask

    task automatic t_faults();
        walk(32'h1234_5678, 32'h8000_4000, 32'h1234_5670, 32'h0, 1, 1'b0);
        chk("R9 l1 type0 done", {31'd0, got_done}, 32'd1);
        chk("R9 l1 type0 fault", {31'd0, fault_o}, 32'd1);
        chk("R9 l1 level", {31'd0, fault_lvl2_o}, 32'd0);
        chk("R9 l1 reads", rd_cnt, 1);
        after_done("R9");
        walk(32'h1234_5678, 32'h8000_4000, 32'hFFFF_FFFF, 32'h0, 1, 1'b0);
        chk("R9 l1 type3 fault", {31'd0, fault_o}, 32'd1);
        chk("R9 l1 type3 reads", rd_cnt, 1);
        after_done("R9");
        walk(32'h0040_3ABC, 32'h8000_4000, 32'h1234_5801, 32'h9876_5A30, 2, 1'b0);
        chk("R9 l2 fault", {31'd0, fault_o}, 32'd1);
        chk("R9 l2 level", {31'd0, fault_lvl2_o}, 32'd1);
        chk("R9 l2 reads", rd_cnt, 2);
        after_done("R9");
    endtask

    task automatic t_stray_rvalid();
        @(negedge clk);
        mem_rvalid_i = 1'b1; mem_rdata_i = 32'hABC0_0002;
        @(negedge clk);
        mem_rvalid_i = 1'b0;
        chk("R10 stray rvalid done", {31'd0, done_o}, 32'd0);
        chk("R10 stray rvalid busy", {31'd0, busy_o}, 32'd0);
        @(negedge clk);
        chk("R10 stray rvalid late", {31'd0, done_o}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_section();
        t_super();
        t_small();
        t_large_hammer();
        t_faults();
        t_stray_rvalid();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule